// File: doc/BRIEF.md
# Drive-Side Task File and Command Front End

This block is the device half of an ATA-style host link. The host selects a register with two active-low chip selects and a three-bit register address, then pulses an active-low read or write strobe. The block holds the 8-bit task-file registers and a 16-bit data port. It interprets the device-control and features bytes and accepts a reduced set of command codes. It raises busy on the clock after a command write, runs a short fixed-length execution phase, and then completes the command.

One command has a data phase: the identify command returns a fixed 80-byte information block as 40 little-endian words through the data register. That data always moves by programmed I/O. Codes that are not in the accepted set are aborted with an error. The soft-reset command puts the task file back to its defaults after a fixed delay. The software-reset bit in the device-control byte does nothing.

The strobes and select lines are sampled on the block clock. A write takes effect on the clock where its strobe is first seen low. The side effects of a read (advancing the data stream, clearing the interrupt) happen on the clock where its strobe is first seen high again. `host_rdata` always shows the currently selected register.

Top module: `ata_tf_top`

## Requirements
- R1: With CS0 low and CS1 high, address 2 selects sector count, 3 sector number, 4 cylinder low, 5 cylinder high and 6 drive select; each reads back the last value written. After reset they read 01h, 01h, 00h, 00h and 00h. A write with both chip selects low, or with both high, changes no register.
- R2: The data register (CS0 low, address 0) is 16 bits wide. Every other register is 8 bits wide and reads with `host_rdata[15:8]` equal to zero.
- R3: Device control is written with CS1 low, CS0 high and address 6. Its bit 2 has no effect on any register or on the status. Its bit 1, when set, holds `intrq` low; a pending interrupt appears again once bit 1 is cleared.
- R4: `xfer_dma` follows features bit 0 (CS0, address 1, write side) whenever no identify data phase is active. It reads 0 throughout an identify data phase, because identify always transfers by PIO.
- R5: After a command write (CS0, address 7) the status shows BSY (bit 7) on the next clock. A command write made while BSY or DRQ (bit 3) is set is ignored.
- R6: Codes 00h, 90h, A0h and EFh complete within EXEC_CYCLES+1 clocks with BSY and DRQ clear, ERR (bit 0) clear, and an interrupt raised. The error register reads 01h after 90h and 00h after the other three.
- R7: Any code outside {00h, 08h, 90h, A0h, A1h, EFh} completes with error register bit 2 (abort) set, status ERR set, no DRQ, and an interrupt raised.
- R8: Identify (A1h) ends execution with DRQ set and BSY clear. The 40 data reads then return words whose low byte is byte 2k and high byte is byte 2k+1 of the block. The block holds: byte 0 manufacturer ID, byte 1 model ID, byte 2 version ID, bytes 10h–1Fh, 20h–2Fh and 30h–3Fh the three 16-character strings with the first character lowest, and zero everywhere else.
- R9: After the 40th data read, BSY and DRQ are clear and an interrupt is raised; with nIEN set, `intrq` stays low.
- R10: Soft reset (08h) holds BSY for SRST_CYCLES clocks. It then returns the task-file registers to their reset values, clears the error register and raises no interrupt.
- R11: Reading status (CS0, address 7) clears a pending interrupt. Reading alternate status (CS1, address 6) does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs0_n | input | 1 | Command-block chip select, active low |
| host_cs1_n | input | 1 | Control-block chip select, active low |
| host_da | input | 3 | Register address |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_wdata | input | 16 | Write data from host |
| host_rdata | output | 16 | Contents of the selected register |
| intrq | output | 1 | Host interrupt request |
| xfer_dma | output | 1 | Transfer mode for the next data phase (1 = DMA) |

## Verification
The bench builds the block with EXEC_CYCLES=3 and SRST_CYCLES=5. These short execution windows let it sweep all 256 command codes and check the abort and diagnostic outcomes of each one, within a small budget. It keeps the default 80-byte identify block with its own ID bytes and strings, so every word of the data phase is compared against a value derived arithmetically from the byte layout. Each task-file register is also written and read back with all 256 values.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_XFER = 2'd2,
    ST_SRST = 2'd3
  } ctl_state_t;

  typedef enum logic [3:0] {
    SEL_NONE    = 4'd0,
    SEL_DATA    = 4'd1,
    SEL_ERRFEAT = 4'd2,
    SEL_SECCNT  = 4'd3,
    SEL_SECNUM  = 4'd4,
    SEL_CYLLO   = 4'd5,
    SEL_CYLHI   = 4'd6,
    SEL_DRVSEL  = 4'd7,
    SEL_STATCMD = 4'd8,
    SEL_ALTCTL  = 4'd9
  } reg_sel_t;

  localparam logic [7:0] CMD_NOP   = 8'h00;
  localparam logic [7:0] CMD_SRST  = 8'h08;
  localparam logic [7:0] CMD_DIAG  = 8'h90;
  localparam logic [7:0] CMD_PKT   = 8'hA0;
  localparam logic [7:0] CMD_IDENT = 8'hA1;
  localparam logic [7:0] CMD_SETF  = 8'hEF;

  localparam logic [7:0] DEF_SECCNT  = 8'h01;
  localparam logic [7:0] DEF_SECNUM  = 8'h01;
  localparam logic [7:0] ERR_ABRT    = 8'h04;
  localparam logic [7:0] ERR_DIAG_OK = 8'h01;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == CMD_NOP) || (c == CMD_SRST) || (c == CMD_DIAG) ||
           (c == CMD_PKT) || (c == CMD_IDENT) || (c == CMD_SETF);
  endfunction

  // character k of a 16-character string, first character in the top byte
  function automatic logic [7:0] str_char(input logic [127:0] s, input int unsigned k);
    logic [127:0] sh;
    sh = s >> (8 * (15 - k));
    return sh[7:0];
  endfunction

  function automatic logic [7:0] ident_byte(
    input int unsigned  idx,
    input logic [7:0]   mfr_id,
    input logic [7:0]   mdl_id,
    input logic [7:0]   ver_id,
    input logic [127:0] s_mfr,
    input logic [127:0] s_mdl,
    input logic [127:0] s_fw
  );
    logic [7:0] b;
    b = 8'h00;
    if (idx == 0)                    b = mfr_id;
    else if (idx == 1)               b = mdl_id;
    else if (idx == 2)               b = ver_id;
    else if (idx >= 16 && idx < 32)  b = str_char(s_mfr, idx - 16);
    else if (idx >= 32 && idx < 48)  b = str_char(s_mdl, idx - 32);
    else if (idx >= 48 && idx < 64)  b = str_char(s_fw,  idx - 48);
    return b;
  endfunction

endpackage

// File: rtl/ata_tf_decode.sv
`timescale 1ns/1ps
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs0_n,
  input  logic       cs1_n,
  input  logic [2:0] da,
  input  logic       rd_n,
  input  logic       wr_n,
  output reg_sel_t   sel,
  output logic       wr_evt,
  output logic       rd_end,
  output reg_sel_t   rd_sel
);

  logic     rd_q;
  logic     wr_q;
  reg_sel_t sel_q;

  always_comb begin
    sel = SEL_NONE;
    if (!cs0_n && cs1_n) begin
      case (da)
        3'd0: sel = SEL_DATA;
        3'd1: sel = SEL_ERRFEAT;
        3'd2: sel = SEL_SECCNT;
        3'd3: sel = SEL_SECNUM;
        3'd4: sel = SEL_CYLLO;
        3'd5: sel = SEL_CYLHI;
        3'd6: sel = SEL_DRVSEL;
        default: sel = SEL_STATCMD;
      endcase
    end else if (cs0_n && !cs1_n && da == 3'd6) begin
      sel = SEL_ALTCTL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      sel_q <= SEL_NONE;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      sel_q <= sel;
    end
  end

  assign wr_evt = wr_q & ~wr_n;
  assign rd_end = ~rd_q & rd_n;
  assign rd_sel = sel_q;

endmodule

// File: rtl/ata_tf_ident.sv
`timescale 1ns/1ps
module ata_tf_ident
  import ata_tf_pkg::*;
#(
  parameter int unsigned  WORDS  = 40,
  parameter logic [7:0]   MFR_ID = 8'h5A,
  parameter logic [7:0]   MDL_ID = 8'h3C,
  parameter logic [7:0]   VER_ID = 8'h11,
  parameter logic [127:0] S_MFR  = "DISK MAKER      ",
  parameter logic [127:0] S_MDL  = "OPTICAL DRIVE 1 ",
  parameter logic [127:0] S_FW   = "FW 2.07         "
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pop,
  output logic [15:0] word,
  output logic        last
);

  localparam int unsigned PW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  assign last   = (32'(ptr_q) == WORDS - 1);
  assign ptr_en = start | pop;

  always_comb begin
    ptr_d = ptr_q;
    if (start)            ptr_d = '0;
    else if (pop && !last) ptr_d = ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign word = {ident_byte(2 * 32'(ptr_q) + 1, MFR_ID, MDL_ID, VER_ID, S_MFR, S_MDL, S_FW),
                 ident_byte(2 * 32'(ptr_q),     MFR_ID, MDL_ID, VER_ID, S_MFR, S_MDL, S_FW)};

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr_q) < WORDS); // R8

  AST_START_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ptr_q == '0)); // R8

endmodule

// File: rtl/ata_tf_ctrl.sv
`timescale 1ns/1ps
module ata_tf_ctrl
  import ata_tf_pkg::*;
#(
  parameter int unsigned EXEC_CYCLES = 4,
  parameter int unsigned SRST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_evt,
  input  logic [7:0] cmd,
  input  logic       pop,
  input  logic       last_word,
  output logic       bsy,
  output logic       drq,
  output logic       err_bit,
  output logic [7:0] err_reg,
  output logic       ident_start,
  output logic       tf_reset,
  output logic       done_pulse
);

  localparam int unsigned CMAX = (EXEC_CYCLES > SRST_CYCLES) ? EXEC_CYCLES : SRST_CYCLES;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  ctl_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    cmd_q, cmd_d;
  logic          errb_q, errb_d;
  logic [7:0]    errr_q, errr_d;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    cmd_d       = cmd_q;
    errb_d      = errb_q;
    errr_d      = errr_q;
    ident_start = 1'b0;
    tf_reset    = 1'b0;
    done_pulse  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_evt) begin
          errb_d  = 1'b0;
          errr_d  = 8'h00;
          cnt_d   = '0;
          cmd_d   = cmd;
          state_d = (cmd == CMD_SRST) ? ST_SRST : ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (cnt_q == CW'(EXEC_CYCLES - 1)) begin
          if (cmd_q == CMD_IDENT) begin
            state_d     = ST_XFER;
            ident_start = 1'b1;
          end else begin
            state_d    = ST_IDLE;
            done_pulse = 1'b1;
            if (!cmd_known(cmd_q)) begin
              errb_d = 1'b1;
              errr_d = ERR_ABRT;
            end else if (cmd_q == CMD_DIAG) begin
              errr_d = ERR_DIAG_OK;
            end
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_XFER: begin
        if (pop && last_word) begin
          state_d    = ST_IDLE;
          done_pulse = 1'b1;
        end
      end
      default: begin
        if (cnt_q == CW'(SRST_CYCLES - 1)) begin
          state_d  = ST_IDLE;
          tf_reset = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= 8'h00;
      errb_q  <= 1'b0;
      errr_q  <= 8'h00;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      errb_q  <= errb_d;
      errr_q  <= errr_d;
    end
  end

  assign bsy     = (state_q == ST_EXEC) || (state_q == ST_SRST);
  assign drq     = (state_q == ST_XFER);
  assign err_bit = errb_q;
  assign err_reg = errr_q;

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd_evt) |=> bsy); // R5

  AST_EXEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> (32'(cnt_q) < EXEC_CYCLES)); // R6

  AST_SRST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRST) |-> (32'(cnt_q) < SRST_CYCLES)); // R10

  AST_ABRT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_bit |-> (err_reg == ERR_ABRT)); // R7

  AST_DRQ_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq) |-> ($past(pop && last_word) && !bsy)); // R9

endmodule

// File: rtl/ata_tf_top.sv
`timescale 1ns/1ps
module ata_tf_top
  import ata_tf_pkg::*;
#(
  parameter int unsigned  EXEC_CYCLES = 4,
  parameter int unsigned  SRST_CYCLES = 8,
  parameter int unsigned  IDENT_BYTES = 80,
  parameter logic [7:0]   MFR_ID      = 8'h5A,
  parameter logic [7:0]   MDL_ID      = 8'h3C,
  parameter logic [7:0]   VER_ID      = 8'h11,
  parameter logic [127:0] S_MFR       = "DISK MAKER      ",
  parameter logic [127:0] S_MDL       = "OPTICAL DRIVE 1 ",
  parameter logic [127:0] S_FW        = "FW 2.07         "
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_cs0_n,
  input  logic        host_cs1_n,
  input  logic [2:0]  host_da,
  input  logic        host_rd_n,
  input  logic        host_wr_n,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        intrq,
  output logic        xfer_dma
);

  localparam int unsigned WORDS = IDENT_BYTES / 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  reg_sel_t sel, rd_sel;
  logic     wr_evt, rd_end;

  ata_tf_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .cs0_n  (host_cs0_n),
    .cs1_n  (host_cs1_n),
    .da     (host_da),
    .rd_n   (host_rd_n),
    .wr_n   (host_wr_n),
    .sel    (sel),
    .wr_evt (wr_evt),
    .rd_end (rd_end),
    .rd_sel (rd_sel)
  );

  logic        bsy, drq, err_bit, ident_start, tf_reset, done_pulse;
  logic [7:0]  err_reg;
  logic        cmd_evt, pop, last_word;
  logic [15:0] id_word;

  assign cmd_evt = wr_evt && (sel == SEL_STATCMD);
  assign pop     = rd_end && (rd_sel == SEL_DATA) && drq;

  ata_tf_ctrl #(
    .EXEC_CYCLES (EXEC_CYCLES),
    .SRST_CYCLES (SRST_CYCLES)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .cmd_evt     (cmd_evt),
    .cmd         (host_wdata[7:0]),
    .pop         (pop),
    .last_word   (last_word),
    .bsy         (bsy),
    .drq         (drq),
    .err_bit     (err_bit),
    .err_reg     (err_reg),
    .ident_start (ident_start),
    .tf_reset    (tf_reset),
    .done_pulse  (done_pulse)
  );

  ata_tf_ident #(
    .WORDS  (WORDS),
    .MFR_ID (MFR_ID),
    .MDL_ID (MDL_ID),
    .VER_ID (VER_ID),
    .S_MFR  (S_MFR),
    .S_MDL  (S_MDL),
    .S_FW   (S_FW)
  ) u_id (
    .clk   (clk),
    .rst_n (rst_s_n),
    .start (ident_start),
    .pop   (pop),
    .word  (id_word),
    .last  (last_word)
  );

  // task-file registers
  logic [7:0] feat_q, feat_d;
  logic [7:0] scnt_q, scnt_d;
  logic [7:0] snum_q, snum_d;
  logic [7:0] cyll_q, cyll_d;
  logic [7:0] cylh_q, cylh_d;
  logic [7:0] drv_q,  drv_d;
  logic [7:0] dctl_q, dctl_d;
  logic       ipend_q, ipend_d;
  logic       tf_we, cmd_taken;

  assign tf_we     = wr_evt && !bsy;
  assign cmd_taken = cmd_evt && !bsy && !drq;

  always_comb begin
    feat_d = feat_q;
    scnt_d = scnt_q;
    snum_d = snum_q;
    cyll_d = cyll_q;
    cylh_d = cylh_q;
    drv_d  = drv_q;
    dctl_d = dctl_q;
    if (tf_reset) begin
      feat_d = 8'h00;
      scnt_d = DEF_SECCNT;
      snum_d = DEF_SECNUM;
      cyll_d = 8'h00;
      cylh_d = 8'h00;
      drv_d  = 8'h00;
    end else if (tf_we) begin
      case (sel)
        SEL_ERRFEAT: feat_d = host_wdata[7:0];
        SEL_SECCNT:  scnt_d = host_wdata[7:0];
        SEL_SECNUM:  snum_d = host_wdata[7:0];
        SEL_CYLLO:   cyll_d = host_wdata[7:0];
        SEL_CYLHI:   cylh_d = host_wdata[7:0];
        SEL_DRVSEL:  drv_d  = host_wdata[7:0];
        default: ;
      endcase
    end
    // device control is writable at any time; only its interrupt mask is used
    if (wr_evt && sel == SEL_ALTCTL) dctl_d = host_wdata[7:0];

    ipend_d = ipend_q;
    if (done_pulse)
      ipend_d = 1'b1;
    else if (cmd_taken || (rd_end && rd_sel == SEL_STATCMD))
      ipend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      feat_q  <= 8'h00;
      scnt_q  <= DEF_SECCNT;
      snum_q  <= DEF_SECNUM;
      cyll_q  <= 8'h00;
      cylh_q  <= 8'h00;
      drv_q   <= 8'h00;
      dctl_q  <= 8'h00;
      ipend_q <= 1'b0;
    end else begin
      feat_q  <= feat_d;
      scnt_q  <= scnt_d;
      snum_q  <= snum_d;
      cyll_q  <= cyll_d;
      cylh_q  <= cylh_d;
      drv_q   <= drv_d;
      dctl_q  <= dctl_d;
      ipend_q <= ipend_d;
    end
  end

  logic [7:0] status;
  assign status = {bsy, ~bsy, 1'b0, 1'b0, drq, 1'b0, 1'b0, err_bit};

  always_comb begin
    host_rdata = 16'h0000;
    case (sel)
      SEL_DATA:    host_rdata = drq ? id_word : 16'h0000;
      SEL_ERRFEAT: host_rdata = {8'h00, err_reg};
      SEL_SECCNT:  host_rdata = {8'h00, scnt_q};
      SEL_SECNUM:  host_rdata = {8'h00, snum_q};
      SEL_CYLLO:   host_rdata = {8'h00, cyll_q};
      SEL_CYLHI:   host_rdata = {8'h00, cylh_q};
      SEL_DRVSEL:  host_rdata = {8'h00, drv_q};
      SEL_STATCMD: host_rdata = {8'h00, status};
      SEL_ALTCTL:  host_rdata = {8'h00, status};
      default:     host_rdata = 16'h0000;
    endcase
  end

  assign intrq    = ipend_q & ~dctl_q[1];
  assign xfer_dma = feat_q[0] & ~drq;

  AST_INT_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ipend_q) |-> $past(done_pulse)); // R9

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_end && rd_sel == SEL_STATCMD && !done_pulse) |=> !ipend_q); // R11

  AST_SRST_NO_INT: assert property (@(posedge clk) disable iff (!rst_s_n)
    tf_reset |=> !ipend_q); // R10

  AST_BUSY_HOLDS_TF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bsy && !tf_reset) |=> $stable(scnt_q)); // R5

endmodule

// File: tb/ata_tf_top_test.sv
`timescale 1ns/1ps
module ata_tf_top_test;

  localparam int EXEC = 3;
  localparam int SRST = 5;
  localparam logic [7:0]   T_MFR = 8'hC3;
  localparam logic [7:0]   T_MDL = 8'h27;
  localparam logic [7:0]   T_VER = 8'h09;
  localparam logic [127:0] T_SMF = "ABCDEFGHIJKLMNOP";
  localparam logic [127:0] T_SMD = "qrstuvwxyz012345";
  localparam logic [127:0] T_SFW = "v9.8.7-RC2 build";

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs0_n = 1'b1, cs1_n = 1'b1;
  logic [2:0]  da = 3'd0;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        intrq, xfer_dma;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ata_tf_top #(
    .EXEC_CYCLES (EXEC), .SRST_CYCLES (SRST), .IDENT_BYTES (80),
    .MFR_ID (T_MFR), .MDL_ID (T_MDL), .VER_ID (T_VER),
    .S_MFR (T_SMF), .S_MDL (T_SMD), .S_FW (T_SFW)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .host_cs0_n (cs0_n), .host_cs1_n (cs1_n), .host_da (da),
    .host_rd_n (rd_n), .host_wr_n (wr_n), .host_wdata (wdata),
    .host_rdata (rdata), .intrq (intrq), .xfer_dma (xfer_dma)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel_reg(input bit alt, input logic [2:0] a);
    cs0_n = alt;
    cs1_n = ~alt;
    da    = a;
  endtask

  task automatic wreg(input bit alt, input logic [2:0] a, input logic [15:0] v);
    @(negedge clk); sel_reg(alt, a); wdata = v; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  task automatic rreg(input bit alt, input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); sel_reg(alt, a); rd_n = 1'b0;
    @(negedge clk); v = rdata; rd_n = 1'b1;
    @(negedge clk); cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  // command write; returns status seen one clock after the write edge
  task automatic cmd(input logic [7:0] c, output logic [7:0] st1);
    @(negedge clk); sel_reg(1'b0, 3'd7); wdata = {8'h00, c}; wr_n = 1'b0;
    @(negedge clk); #1 st1 = rdata[7:0]; wr_n = 1'b1;
    @(negedge clk); cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk); sel_reg(1'b1, 3'd6); #1;
      n = i;
      if (!rdata[7]) break;
    end
    cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    if (i == 0) return T_MFR;
    if (i == 1) return T_MDL;
    if (i == 2) return T_VER;
    if (i >= 16 && i < 32) return T_SMF[8*(31-i) +: 8];
    if (i >= 32 && i < 48) return T_SMD[8*(47-i) +: 8];
    if (i >= 48 && i < 64) return T_SFW[8*(63-i) +: 8];
    return 8'h00;
  endfunction

  function automatic bit known(input logic [7:0] c);
    return c == 8'h00 || c == 8'h08 || c == 8'h90 || c == 8'hA0 || c == 8'hA1 || c == 8'hEF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  st;
    int          n;
    int          errs;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rreg(1'b1, 3'd6, v); chk(v == 16'h0040, "R1 reset status", v, 16'h0040);
    rreg(1'b0, 3'd2, v); chk(v == 16'h0001, "R1 reset seccnt", v, 1);
    rreg(1'b0, 3'd3, v); chk(v == 16'h0001, "R1 reset secnum", v, 1);
    rreg(1'b0, 3'd6, v); chk(v == 16'h0000, "R1 reset drvsel", v, 0);
    chk(intrq == 1'b0, "R1 reset intrq", intrq, 0);

    // R1/R2: exhaustive write-readback on the five task-file registers
    for (int a = 2; a <= 6; a++) begin
      errs = 0;
      for (int d = 0; d < 256; d++) begin
        wreg(1'b0, 3'(a), {8'hFF, 8'(d)});
        rreg(1'b0, 3'(a), v);
        if (v != {8'h00, 8'(d)}) begin
          errs++;
          if (errs == 1) chk(1'b0, "R1 R2 readback", v, d);
        end
      end
      if (errs == 0) chk(1'b1, "R1 R2 readback", 0, 0);
    end

    // R1: both or neither chip select -> no write
    wreg(1'b0, 3'd2, 16'h0055);
    @(negedge clk); cs0_n = 1'b0; cs1_n = 1'b0; da = 3'd2; wdata = 16'h00AA; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs0_n = 1'b1; cs1_n = 1'b1; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    rreg(1'b0, 3'd2, v); chk(v == 16'h0055, "R1 bad select ignored", v, 16'h55);

    // R3: software reset bit has no effect
    wreg(1'b1, 3'd6, 16'h0004);
    rreg(1'b0, 3'd2, v); chk(v == 16'h0055, "R3 srst bit no reset", v, 16'h55);
    rreg(1'b1, 3'd6, v); chk(v == 16'h0040, "R3 srst bit status idle", v, 16'h40);

    // R5: busy next clock; R6: NOP completion
    wreg(1'b1, 3'd6, 16'h0000);
    cmd(8'h00, st);
    chk(st[7] == 1'b1, "R5 busy after write", st, 8'h80);
    wait_idle(n);
    chk(n <= EXEC + 1, "R6 completion time", n, EXEC + 1);
    chk(intrq == 1'b1, "R6 interrupt raised", intrq, 1);

    // R11: alt status read keeps it, status read clears it
    rreg(1'b1, 3'd6, v); chk(intrq == 1'b1, "R11 alt read keeps int", intrq, 1);
    rreg(1'b0, 3'd7, v); chk(intrq == 1'b0, "R11 status read clears", intrq, 0);

    // R3: nIEN masks, pending returns when cleared
    wreg(1'b1, 3'd6, 16'h0002);
    cmd(8'hEF, st);
    wait_idle(n);
    @(negedge clk);
    chk(intrq == 1'b0, "R3 nIEN masks", intrq, 0);
    wreg(1'b1, 3'd6, 16'h0000);
    chk(intrq == 1'b1, "R3 pending after unmask", intrq, 1);
    rreg(1'b0, 3'd7, v);

    // R6/R7: sweep every code except soft reset and identify
    errs = 0;
    for (int c = 0; c < 256; c++) begin
      logic [7:0] ee, es;
      if (c == 8'h08 || c == 8'hA1) continue;
      cmd(8'(c), st);
      wait_idle(n);
      ee = known(8'(c)) ? ((c == 8'h90) ? 8'h01 : 8'h00) : 8'h04;
      es = known(8'(c)) ? 8'h40 : 8'h41;
      rreg(1'b0, 3'd1, v);
      if (v != {8'h00, ee} || !intrq) begin
        errs++;
        chk(1'b0, known(8'(c)) ? "R6 error reg" : "R7 abort reg", v, ee);
      end
      rreg(1'b0, 3'd7, v);
      if (v != {8'h00, es} || intrq) begin
        errs++;
        chk(1'b0, known(8'(c)) ? "R6 status" : "R7 status", v, es);
      end
    end
    if (errs == 0) begin
      chk(1'b1, "R6 sweep", 0, 0);
      chk(1'b1, "R7 sweep", 0, 0);
    end

    // R4: features bit 0 drives mode, forced PIO during identify
    wreg(1'b0, 3'd1, 16'h0001);
    chk(xfer_dma == 1'b1, "R4 dma mode selected", xfer_dma, 1);
    cmd(8'hA1, st);
    wait_idle(n);
    rreg(1'b1, 3'd6, v); chk(v == 16'h0048, "R8 drq set", v, 16'h48);
    chk(xfer_dma == 1'b0, "R4 identify is PIO", xfer_dma, 0);
    cmd(8'h00, st);
    rreg(1'b1, 3'd6, v); chk(v == 16'h0048, "R5 cmd ignored during drq", v, 16'h48);
    errs = 0;
    for (int w = 0; w < 40; w++) begin
      logic [15:0] ex;
      ex = {exp_byte(2*w + 1), exp_byte(2*w)};
      rreg(1'b0, 3'd0, v);
      if (v != ex) begin
        errs++;
        if (errs <= 3) chk(1'b0, "R8 identify word", v, ex);
      end
    end
    if (errs == 0) chk(1'b1, "R8 identify words", 0, 0);
    rreg(1'b1, 3'd6, v); chk(v == 16'h0040, "R9 status after last", v, 16'h40);
    chk(intrq == 1'b1, "R9 interrupt after last", intrq, 1);
    chk(xfer_dma == 1'b1, "R4 mode restored", xfer_dma, 1);
    rreg(1'b0, 3'd7, v);

    // R9: identify with nIEN set
    wreg(1'b1, 3'd6, 16'h0002);
    cmd(8'hA1, st);
    wait_idle(n);
    for (int w = 0; w < 40; w++) rreg(1'b0, 3'd0, v);
    rreg(1'b1, 3'd6, v); chk(v == 16'h0040, "R9 done masked", v, 16'h40);
    chk(intrq == 1'b0, "R9 nIEN holds low", intrq, 0);
    wreg(1'b1, 3'd6, 16'h0000);
    rreg(1'b0, 3'd7, v);

    // R10: soft reset
    wreg(1'b0, 3'd2, 16'h0077);
    wreg(1'b0, 3'd4, 16'h0012);
    wreg(1'b0, 3'd6, 16'h00A0);
    cmd(8'hFF, st);
    wait_idle(n);
    rreg(1'b0, 3'd7, v);
    cmd(8'h08, st);
    chk(st[7] == 1'b1, "R10 busy on soft reset", st, 8'h80);
    wait_idle(n);
    chk(n <= SRST + 1, "R10 reset time", n, SRST + 1);
    chk(n >= SRST - 2, "R10 reset held", n, SRST - 2);
    rreg(1'b0, 3'd2, v); chk(v == 16'h0001, "R10 seccnt default", v, 1);
    rreg(1'b0, 3'd4, v); chk(v == 16'h0000, "R10 cyllo default", v, 0);
    rreg(1'b0, 3'd6, v); chk(v == 16'h0000, "R10 drvsel default", v, 0);
    rreg(1'b0, 3'd1, v); chk(v == 16'h0000, "R10 error cleared", v, 0);
    chk(intrq == 1'b0, "R10 no interrupt", intrq, 0);
    chk(xfer_dma == 1'b0, "R10 features cleared", xfer_dma, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule